// File: doc/BRIEF.md
# Wrapped burst quadword order generator

This block produces, for every data cycle of an eight-cycle system data transfer, the address bits [5:3] of the quadword being moved into or out of a 64-byte cache block. The system controller starts a transfer with a one-cycle start request carrying a 3-bit data command code, a 2-bit starting-point field and a transfer-size class. The block then emits eight valid cycles, each with a quadword index, and pulses done on the last of them.

Two orderings exist. For block and quadword transfers the starting field names a 16-byte pair; successive pairs follow an XOR (interleaved) wrap from that pair, and each pair is emitted lower quadword first. For longword and byte/word reads the field names one of four quadwords in the lower 32-byte half; four distinct quadwords follow the same XOR wrap, each held for two consecutive cycles. The command code is decoded into a type that stays on its output for the whole transfer, and unknown codes are rejected without starting anything.

Top module: `wrap_qw_gen`

## Requirements
- R1: While rst_ni is low (asynchronous, active low) valid_o, done_o and cmd_err_o are 0 and cmd_type_o is 0; a reset during a transfer ends it at once.
- R2: A start_i sampled high while idle with a legal code makes valid_o high from the next cycle for exactly eight consecutive cycles, then low.
- R3: done_o is high on the eighth valid cycle only.
- R4: With narrow_i = 0, on valid cycle c (0..7) qw_idx_o = {start_pt_i XOR c[2:1], c[0]}, so eight distinct quadwords are emitted.
- R5: With narrow_i = 1, on valid cycle c qw_idx_o = {1'b0, start_pt_i XOR c[2:1]}, each of four quadwords on two consecutive cycles.
- R6: cmd_type_o decodes the code latched at start and holds it on every valid cycle: 100 gives 1 (read), 101 gives 2 (read dirty), 110 gives 3 (read shared), 111 gives 4 (read shared dirty), 010 gives 5 (write); it is 0 when idle.
- R7: A start_i while idle with code 000, 001 or 011 raises cmd_err_o for exactly the next cycle and starts no transfer.
- R8: A start_i arriving while a transfer runs (including its done cycle) is ignored: order, type and length of the running transfer are unchanged.
- R9: start_pt_i, narrow_i and cmd_i are sampled only when a start is accepted; later changes have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| cmd_i | input | 3 | Data command code |
| start_pt_i | input | 2 | System-supplied starting point |
| narrow_i | input | 1 | 1 = longword or byte/word read (double-pumped) |
| qw_idx_o | output | 3 | Quadword index, address bits [5:3] |
| valid_o | output | 1 | Index valid this cycle |
| cmd_type_o | output | 3 | Decoded command type |
| cmd_err_o | output | 1 | Illegal command pulse |
| done_o | output | 1 | Last valid cycle |

## Verification
The bench walks every legal code in both size classes with several start points, including start 3 where the XOR wrap differs most from a linear increment; a design that incremented instead of XOR-ing would emit the wrong pair from the second pass. Double-pumped runs catch a design that advanced every cycle or repeated the wrong quadword. A start pulse with scrambled fields in the middle of a transfer catches a block that restarts or re-samples its inputs, and the three illegal codes catch a block that starts anyway or leaves its error flag stuck.

// File: rtl/wrap_qw_pkg.sv
package wrap_qw_pkg;
  typedef enum logic [2:0] {
    CT_NONE         = 3'd0,
    CT_RD           = 3'd1,
    CT_RD_DIRTY     = 3'd2,
    CT_RD_SHR       = 3'd3,
    CT_RD_SHR_DIRTY = 3'd4,
    CT_WR           = 3'd5
  } cmd_type_e;
endpackage

// File: rtl/wrap_cmd_decode.sv
module wrap_cmd_decode
  import wrap_qw_pkg::*;
(
  input  logic [2:0] code_i,
  output cmd_type_e  type_o,
  output logic       legal_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (code_i)
      3'b100:  type_o = CT_RD;
      3'b101:  type_o = CT_RD_DIRTY;
      3'b110:  type_o = CT_RD_SHR;
      3'b111:  type_o = CT_RD_SHR_DIRTY;
      3'b010:  type_o = CT_WR;
      default: begin
        type_o  = CT_NONE;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/wrap_beat_ctr.sv
module wrap_beat_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  logic             busy_q;
  logic [CNT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      beat_q <= '0;
    end else if (busy_q) begin
      if (beat_q == LAST_BEAT) busy_q <= 1'b0;
      beat_q <= beat_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;
  assign last_o = busy_q && (beat_q == LAST_BEAT);
endmodule

// File: rtl/wrap_idx_gen.sv
module wrap_idx_gen #(
  parameter int unsigned IDX_W = 3,
  parameter bit          DP_EN = 1'b1
) (
  input  logic [IDX_W-1:0] beat_i,
  input  logic [IDX_W-2:0] start_pt_i,
  input  logic             narrow_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned PW = IDX_W - 1;

  logic [PW-1:0]    wrap_sel;
  logic [IDX_W-1:0] blk_idx;

  // interleaved wrap: XOR start with pass number
  assign wrap_sel = start_pt_i ^ beat_i[IDX_W-1:1];
  assign blk_idx  = {wrap_sel, beat_i[0]};

  generate
    if (DP_EN) begin : g_dp
      logic [IDX_W-1:0] dp_idx;
      assign dp_idx = {1'b0, wrap_sel};
      assign idx_o  = narrow_i ? dp_idx : blk_idx;
    end else begin : g_blk
      logic unused_narrow;
      assign unused_narrow = narrow_i;
      assign idx_o = blk_idx;
    end
  endgenerate
endmodule

// File: rtl/wrap_qw_gen.sv
module wrap_qw_gen
  import wrap_qw_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter bit          DP_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       cmd_i,
  input  logic [IDX_W-2:0] start_pt_i,
  input  logic             narrow_i,
  output logic [IDX_W-1:0] qw_idx_o,
  output logic             valid_o,
  output logic [2:0]       cmd_type_o,
  output logic             cmd_err_o,
  output logic             done_o
);
  localparam int unsigned SP_W = IDX_W - 1;

  cmd_type_e        dec_type;
  logic             dec_legal;
  logic             busy, last, accept, reject;
  logic [IDX_W-1:0] beat;

  logic [SP_W-1:0]  sp_q;
  logic             narrow_q;
  cmd_type_e        type_q;
  logic             err_q;

  wrap_cmd_decode u_dec (
    .code_i  (cmd_i),
    .type_o  (dec_type),
    .legal_o (dec_legal)
  );

  assign accept = start_i && !busy && dec_legal;
  assign reject = start_i && !busy && !dec_legal;

  wrap_beat_ctr #(.CNT_W(IDX_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .busy_o (busy),
    .beat_o (beat),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q     <= '0;
      narrow_q <= 1'b0;
      type_q   <= CT_NONE;
      err_q    <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept) begin
        sp_q     <= start_pt_i;
        narrow_q <= narrow_i;
        type_q   <= dec_type;
      end
    end
  end

  wrap_idx_gen #(.IDX_W(IDX_W), .DP_EN(DP_EN)) u_idx (
    .beat_i     (beat),
    .start_pt_i (sp_q),
    .narrow_i   (narrow_q),
    .idx_o      (qw_idx_o)
  );

  assign valid_o    = busy;
  assign done_o     = last;
  assign cmd_err_o  = err_q;
  assign cmd_type_o = busy ? type_q : CT_NONE;
endmodule

// File: rtl/wrap_qw_gen_chk.sv
module wrap_qw_gen_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       cmd_i,
  input logic [IDX_W-1:0] qw_idx_o,
  input logic             valid_o,
  input logic [2:0]       cmd_type_o,
  input logic             cmd_err_o,
  input logic             done_o,
  input logic             narrow_q
);
  logic [IDX_W-1:0] cnt_q;
  logic             legal;

  assign legal = (cmd_i[2] == 1'b1) || (cmd_i == 3'b010);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_o) cnt_q <= cnt_q + 1'b1;
  end

  // R3
  done_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (valid_o && cnt_q == {IDX_W{1'b1}}));
  // R2
  run_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o) |=> valid_o);
  // R2
  run_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !valid_o);
  // R2
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_o && legal) |=> valid_o);
  // R7
  bad_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_o && !legal) |=> (cmd_err_o && !valid_o));
  // R5
  dp_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && narrow_q && cnt_q[0]) |-> (qw_idx_o == $past(qw_idx_o) && !qw_idx_o[IDX_W-1]));
  // R4
  blk_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !narrow_q) |-> (qw_idx_o[0] == cnt_q[0]));
  // R6
  type_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> $stable(cmd_type_o));
  // R6
  type_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (cmd_type_o != 3'd0));
endmodule

bind wrap_qw_gen wrap_qw_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cmd_i      (cmd_i),
  .qw_idx_o   (qw_idx_o),
  .valid_o    (valid_o),
  .cmd_type_o (cmd_type_o),
  .cmd_err_o  (cmd_err_o),
  .done_o     (done_o),
  .narrow_q   (narrow_q)
);

// File: tb/sim_wrap_qw_gen.sv
module sim_wrap_qw_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] cmd_i = 3'b000;
  logic [1:0] start_pt_i = 2'b00;
  logic       narrow_i = 1'b0;
  logic [2:0] qw_idx_o;
  logic       valid_o;
  logic [2:0] cmd_type_o;
  logic       cmd_err_o;
  logic       done_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  wrap_qw_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .start_pt_i(start_pt_i), .narrow_i(narrow_i), .qw_idx_o(qw_idx_o),
    .valid_o(valid_o), .cmd_type_o(cmd_type_o), .cmd_err_o(cmd_err_o),
    .done_o(done_o)
  );

  // {cmd[2:0], narrow, start_pt[1:0], expected type[2:0]}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {3'b100, 1'b0, 2'd0, 3'd1},
    {3'b101, 1'b0, 2'd1, 3'd2},
    {3'b110, 1'b0, 2'd2, 3'd3},
    {3'b111, 1'b0, 2'd3, 3'd4},
    {3'b010, 1'b0, 2'd2, 3'd5},
    {3'b100, 1'b1, 2'd0, 3'd1},
    {3'b101, 1'b1, 2'd3, 3'd2},
    {3'b010, 1'b1, 2'd1, 3'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_idx(input logic nar, input logic [1:0] sp, input int c);
    logic [1:0] w;
    w = sp ^ 2'(c >> 1);
    return nar ? {1'b0, w} : {w, 1'(c & 1)};
  endfunction

  // disturb: pulse start with scrambled fields mid-run (R8, R9)
  task automatic run_seq(input logic [2:0] cmd, input logic nar, input logic [1:0] sp,
                         input logic [2:0] ety, input bit disturb);
    @(negedge clk_i);
    start_i = 1'b1; cmd_i = cmd; narrow_i = nar; start_pt_i = sp;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (disturb) begin
        start_pt_i = ~sp; narrow_i = ~nar; cmd_i = 3'b111;
        start_i = (c == 3 || c == 7);
      end
      chk(valid_o == 1'b1, "R2 valid", int'(valid_o), 1);
      chk(qw_idx_o == exp_idx(nar, sp, c), nar ? "R5 idx" : "R4 idx",
          int'(qw_idx_o), int'(exp_idx(nar, sp, c)));
      chk(done_o == (c == 7), "R3 done", int'(done_o), int'(c == 7));
      chk(cmd_type_o == ety, disturb ? "R8 type" : "R6 type", int'(cmd_type_o), int'(ety));
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(valid_o == 1'b0, disturb ? "R8 end" : "R2 end", int'(valid_o), 0);
    chk(cmd_type_o == 3'd0, "R6 idle", int'(cmd_type_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(cmd_err_o == 1'b0, "R1 err", int'(cmd_err_o), 0);
    chk(cmd_type_o == 3'd0, "R1 type", int'(cmd_type_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++)
      run_seq(VEC[i][8:6], VEC[i][5], VEC[i][4:3], VEC[i][2:0], 1'b0);

    // R8 R9: start and field changes during a run are ignored
    run_seq(3'b100, 1'b0, 2'd1, 3'd1, 1'b1);
    run_seq(3'b010, 1'b1, 2'd2, 3'd5, 1'b1);

    // R7 illegal codes
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      start_i = 1'b1;
      cmd_i = (k == 0) ? 3'b000 : (k == 1) ? 3'b001 : 3'b011;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(cmd_err_o == 1'b1, "R7 err", int'(cmd_err_o), 1);
      chk(valid_o == 1'b0, "R7 no run", int'(valid_o), 0);
      @(negedge clk_i);
      chk(cmd_err_o == 1'b0, "R7 pulse", int'(cmd_err_o), 0);
      chk(valid_o == 1'b0, "R7 still idle", int'(valid_o), 0);
    end

    // R1 reset during a run
    @(negedge clk_i);
    start_i = 1'b1; cmd_i = 3'b110; narrow_i = 1'b0; start_pt_i = 2'd3;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R1 abort", int'(valid_o), 0);
    chk(cmd_type_o == 3'd0, "R1 abort type", int'(cmd_type_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 stays idle", int'(valid_o), 0);
    run_seq(3'b111, 1'b1, 2'd2, 3'd4, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule